// File: doc/BRIEF.md
# ATA Task-File Command Controller

This block is the device-side register file and command sequencer of a parallel ATA disk that uses LBA addressing. A host reaches it through a 3-bit register address with separate read and write strobes. The task-file registers are byte wide, and the data register is 16 bits wide. A write to the command address starts a command. The block owns the status byte, raises an interrupt when a command completes, and clears that interrupt when the host reads status.

Four commands are supported. For the two DMA commands, the block asserts a request, together with a direction, toward a companion bus-master engine, and holds the device busy until the engine reports that the transfer is done. For the cache flush, it raises a request toward the storage back end and stays busy until a done input returns. For the identify command, it streams 256 words through the data register, and the data-request bit gates each word. Serial number, firmware version and capacity are parameters. The storage medium itself sits behind the DMA and flush handshakes.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset, status (offset 7) reads 0x40, irq_o is low, and dma_req_o and flush_req_o are low. Status bits are BSY=bit 7, DRDY=bit 6, DF=bit 5, DRQ=bit 3 and ERR=bit 0. DRDY always reads 1 and DF always reads 0.
- R2: Offsets 2, 3, 4, 5 and 6 hold the sector count, the LBA bits 7:0, 15:8 and 23:16, and the device register. Each reads back the last byte written to it, in the low byte of the read data. count_o and lba_o present the same values. Bit 4 of the device register reads back as written, so a command issued to device 0 leaves it at 0.
- R3: Command 0xC8 makes status read 0xC0, with dma_req_o=1 and dma_dir_o=1 (device to host), until a dma_done_i pulse arrives. In the next cycle status reads 0x40, dma_req_o is 0 and irq_o is 1.
- R4: Command 0xCA behaves as R3 but with dma_dir_o=0 (host to device).
- R5: Command 0xE7 makes status read 0xC0 with flush_req_o=1 until flush_done_i is seen. Status then reads 0x40, flush_req_o drops and irq_o rises.
- R6: Command 0xEC makes status read 0x48. Each read of offset 0 returns one identify word and advances to the next. After the 256th read, status reads 0x40. Offset 0 reads 0 when DRQ is clear. Identify does not raise irq_o.
- R7: The identify words are as follows. Word 0 is 0x0040. Words 10-19 hold the 20-character serial and words 23-26 hold the 8-character version, with the first character of each pair in the high byte. Word 49 is 0x0300. Words 60 and 61 hold capacity bits 15:0 and 31:16. Words 82 and 85 are 0x0020 (word 85 bit 5 reports that the write cache is enabled). All other words are 0.
- R8: A host read of status clears irq_o in the next cycle, unless a completion occurs in the same cycle, in which case irq_o is set.
- R9: Any other opcode sets status to 0x41 and raises irq_o. While ERR is set, offset 1 reads 0x04. The next accepted command clears ERR.
- R10: A command write while BSY is set is ignored. The running command, its direction and its requests are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hst_addr_i | input | 3 | Register offset |
| hst_wr_i | input | 1 | Register write strobe |
| hst_rd_i | input | 1 | Register read strobe (side effects on status and data) |
| hst_wdata_i | input | 8 | Write data |
| hst_rdata_o | output | 16 | Read data for hst_addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA transfer requested from bus-master engine |
| dma_dir_o | output | 1 | 1 = device to host, 0 = host to device |
| dma_done_i | input | 1 | Engine reports transfer finished |
| flush_req_o | output | 1 | Cache flush requested from back end |
| flush_done_i | input | 1 | Back end reports flush finished |
| count_o | output | 8 | Sector count register |
| lba_o | output | 24 | LBA address |

## Verification
On every cycle, the assertions check the status invariants. A DMA or flush request never appears without BSY. DRQ never coexists with BSY or ERR. A status read without a completion always leaves the interrupt low. A command written while busy never disturbs the running command. The identify stream ending after its last word is also checked by property. The data itself can only be shown by the bench's scenarios: the exact content of each identify word, the string byte order, the register readback, and the sequence of status values through DMA, flush and rejected opcodes under random timing of the done inputs.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DF   = 5;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  localparam logic [7:0] OP_RD_DMA = 8'hC8;
  localparam logic [7:0] OP_WR_DMA = 8'hCA;
  localparam logic [7:0] OP_FLUSH  = 8'hE7;
  localparam logic [7:0] OP_IDENT  = 8'hEC;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_ERR  = 3'd1;
  localparam logic [2:0] A_CNT  = 3'd2;
  localparam logic [2:0] A_LBA0 = 3'd3;
  localparam logic [2:0] A_DEV  = 3'd6;
  localparam logic [2:0] A_CMD  = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_DMA, S_FLUSH, S_PIO} seq_state_e;
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter int LBA_BYTES = 3,
  localparam int LBA_W = 8 * LBA_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       count_o,
  output logic [LBA_W-1:0] lba_o,
  output logic [7:0]       dev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      dev_o   <= '0;
    end else if (wr_i) begin
      if (addr_i == A_CNT) count_o <= wdata_i;
      if (addr_i == A_DEV) dev_o   <= wdata_i;
    end
  end

  for (genvar g = 0; g < LBA_BYTES; g++) begin : g_lba
    localparam logic [2:0] ADDR = 3'(int'(A_LBA0) + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    lba_o[8*g +: 8] <= '0;
      else if (wr_i && addr_i == ADDR) lba_o[8*g +: 8] <= wdata_i;
    end
  end
endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
  parameter int          IDX_W       = 8,
  parameter int          SER_CHARS   = 20,
  parameter int          VER_CHARS   = 8,
  parameter logic [8*SER_CHARS-1:0] SERIAL_STR  = "testdisk            ",
  parameter logic [8*VER_CHARS-1:0] VERSION_STR = "version ",
  parameter logic [31:0] CAPACITY    = 32'h0002_0000,
  localparam int SER_FIRST = 10,
  localparam int SER_LAST  = SER_FIRST + SER_CHARS/2 - 1,
  localparam int VER_FIRST = 23,
  localparam int VER_LAST  = VER_FIRST + VER_CHARS/2 - 1
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [15:0]      word_o
);
  int i;
  always_comb begin
    i = int'(idx_i);
    word_o = '0;
    if (i >= SER_FIRST && i <= SER_LAST)
      word_o = SERIAL_STR[8*SER_CHARS-1 - 16*(i-SER_FIRST) -: 16];
    else if (i >= VER_FIRST && i <= VER_LAST)
      word_o = VERSION_STR[8*VER_CHARS-1 - 16*(i-VER_FIRST) -: 16];
    else begin
      case (i)
        0:       word_o = 16'h0040;   // fixed disk
        49:      word_o = 16'h0300;   // LBA + DMA capable
        60:      word_o = CAPACITY[15:0];
        61:      word_o = CAPACITY[31:16];
        82:      word_o = 16'h0020;   // write cache supported
        85:      word_o = 16'h0020;   // write cache enabled
        default: word_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
  import ata_tf_pkg::*;
#(
  parameter int IDENT_WORDS = 256,
  localparam int IDX_W = $clog2(IDENT_WORDS),
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(IDENT_WORDS - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic [7:0]       cmd_i,
  input  logic             st_rd_i,
  input  logic             data_rd_i,
  input  logic             dma_done_i,
  input  logic             flush_done_i,
  output logic [7:0]       status_o,
  output logic             irq_o,
  output logic             dma_req_o,
  output logic             dma_dir_o,
  output logic             flush_req_o,
  output logic [IDX_W-1:0] idx_o
);
  seq_state_e state_q;
  logic err_q, bsy, drq, accept, known_op, cmpl;

  assign bsy      = (state_q == S_DMA) || (state_q == S_FLUSH);
  assign drq      = (state_q == S_PIO);
  assign accept   = cmd_wr_i && !bsy;
  assign known_op = (cmd_i == OP_RD_DMA) || (cmd_i == OP_WR_DMA) ||
                    (cmd_i == OP_FLUSH)  || (cmd_i == OP_IDENT);
  assign cmpl     = (state_q == S_DMA && dma_done_i) ||
                    (state_q == S_FLUSH && flush_done_i) ||
                    (accept && !known_op);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      err_q     <= 1'b0;
      dma_dir_o <= 1'b0;
      idx_o     <= '0;
    end else if (accept) begin
      err_q <= 1'b0;
      idx_o <= '0;
      case (cmd_i)
        OP_RD_DMA: begin state_q <= S_DMA; dma_dir_o <= 1'b1; end
        OP_WR_DMA: begin state_q <= S_DMA; dma_dir_o <= 1'b0; end
        OP_FLUSH:  state_q <= S_FLUSH;
        OP_IDENT:  state_q <= S_PIO;
        default: begin state_q <= S_IDLE; err_q <= 1'b1; end
      endcase
    end else begin
      case (state_q)
        S_DMA:   if (dma_done_i)   state_q <= S_IDLE;
        S_FLUSH: if (flush_done_i) state_q <= S_IDLE;
        S_PIO: if (data_rd_i) begin
          if (idx_o == IDX_LAST) state_q <= S_IDLE;
          else                   idx_o <= idx_o + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_o <= 1'b0;
    else if (cmpl)    irq_o <= 1'b1;
    else if (st_rd_i) irq_o <= 1'b0;
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_BSY]  = bsy;
    status_o[ST_DRDY] = 1'b1;
    status_o[ST_DF]   = 1'b0;
    status_o[ST_DRQ]  = drq;
    status_o[ST_ERR]  = err_q;
  end

  assign dma_req_o   = (state_q == S_DMA);
  assign flush_req_o = (state_q == S_FLUSH);

  a_r3_dma_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> status_o[ST_BSY]);
  a_r5_flush_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> (status_o[ST_BSY] && !dma_req_o));
  a_r6_drq_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_DRQ] |-> (!status_o[ST_BSY] && !status_o[ST_ERR]));
  a_r6_last_word_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq && data_rd_i && !cmd_wr_i && idx_o == IDX_LAST) |=> !status_o[ST_DRQ]);
  a_r8_read_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_rd_i && !cmpl) |=> !irq_o);
  a_r10_busy_cmd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && bsy && !dma_done_i && !flush_done_i)
      |=> (status_o[ST_BSY] && $stable(dma_dir_o) && $stable(dma_req_o)));
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
  import ata_tf_pkg::*;
#(
  parameter int          IDENT_WORDS = 256,
  parameter int          SER_CHARS   = 20,
  parameter int          VER_CHARS   = 8,
  parameter logic [8*SER_CHARS-1:0] SERIAL_STR  = "testdisk            ",
  parameter logic [8*VER_CHARS-1:0] VERSION_STR = "version ",
  parameter logic [31:0] CAPACITY    = 32'h0002_0000,
  parameter int          LBA_BYTES   = 3,
  localparam int IDX_W = $clog2(IDENT_WORDS),
  localparam int LBA_W = 8 * LBA_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       hst_addr_i,
  input  logic             hst_wr_i,
  input  logic             hst_rd_i,
  input  logic [7:0]       hst_wdata_i,
  output logic [15:0]      hst_rdata_o,
  output logic             irq_o,
  output logic             dma_req_o,
  output logic             dma_dir_o,
  input  logic             dma_done_i,
  output logic             flush_req_o,
  input  logic             flush_done_i,
  output logic [7:0]       count_o,
  output logic [LBA_W-1:0] lba_o
);
  logic [7:0]       dev, status;
  logic [IDX_W-1:0] idx;
  logic [15:0]      ident_word;
  logic             cmd_wr, st_rd, data_rd;

  assign cmd_wr  = hst_wr_i && hst_addr_i == A_CMD;
  assign st_rd   = hst_rd_i && hst_addr_i == A_CMD;
  assign data_rd = hst_rd_i && hst_addr_i == A_DATA && status[ST_DRQ];

  ata_tf_regs #(.LBA_BYTES(LBA_BYTES)) u_regs (
    .clk_i, .rst_ni, .wr_i(hst_wr_i), .addr_i(hst_addr_i), .wdata_i(hst_wdata_i),
    .count_o, .lba_o, .dev_o(dev)
  );

  ata_tf_seq #(.IDENT_WORDS(IDENT_WORDS)) u_seq (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .cmd_i(hst_wdata_i), .st_rd_i(st_rd),
    .data_rd_i(data_rd), .dma_done_i, .flush_done_i, .status_o(status), .irq_o,
    .dma_req_o, .dma_dir_o, .flush_req_o, .idx_o(idx)
  );

  ata_tf_ident #(
    .IDX_W(IDX_W), .SER_CHARS(SER_CHARS), .VER_CHARS(VER_CHARS),
    .SERIAL_STR(SERIAL_STR), .VERSION_STR(VERSION_STR), .CAPACITY(CAPACITY)
  ) u_ident (.idx_i(idx), .word_o(ident_word));

  always_comb begin
    hst_rdata_o = '0;
    case (hst_addr_i)
      A_DATA:  hst_rdata_o = status[ST_DRQ] ? ident_word : 16'h0000;
      A_ERR:   hst_rdata_o = {13'd0, status[ST_ERR], 2'd0};
      A_CNT:   hst_rdata_o = {8'd0, count_o};
      A_DEV:   hst_rdata_o = {8'd0, dev};
      A_CMD:   hst_rdata_o = {8'd0, status};
      default: hst_rdata_o = {8'd0, lba_o[8*(int'(hst_addr_i) - int'(A_LBA0)) +: 8]};
    endcase
  end

  a_r9_err_reads_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hst_addr_i == A_ERR) |-> (hst_rdata_o[2] == status[ST_ERR]));
  a_r1_df_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status[ST_DF] && status[ST_DRDY]);
endmodule

// File: tb/ata_taskfile_ctrl_bench.sv
module ata_taskfile_ctrl_bench;
  localparam logic [159:0] SER = "testdisk            ";
  localparam logic [63:0]  VER = "version ";
  localparam logic [31:0]  CAP = 32'h0002_0000;

  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr = 0, rd = 0, dma_done = 0, flush_done = 0;
  logic [7:0] wdata = 0, count;
  logic [15:0] rdata;
  logic irq, dma_req, dma_dir, flush_req;
  logic [23:0] lba;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  ata_taskfile_ctrl #(.SERIAL_STR(SER), .VERSION_STR(VER), .CAPACITY(CAP)) u_ata_taskfile_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hst_addr_i(addr), .hst_wr_i(wr), .hst_rd_i(rd),
    .hst_wdata_i(wdata), .hst_rdata_o(rdata), .irq_o(irq), .dma_req_o(dma_req),
    .dma_dir_o(dma_dir), .dma_done_i(dma_done), .flush_req_o(flush_req),
    .flush_done_i(flush_done), .count_o(count), .lba_o(lba)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic pulse_dma;
    @(negedge clk); dma_done = 1; @(posedge clk); #1 dma_done = 0;
  endtask

  function automatic logic [7:0] sbyte(input int j);
    return SER[159 - 8*j -: 8];
  endfunction
  function automatic logic [7:0] vbyte(input int j);
    return VER[63 - 8*j -: 8];
  endfunction

  function automatic logic [15:0] ident_exp(input int w);
    if (w >= 10 && w < 20) return {sbyte(2*(w-10)), sbyte(2*(w-10)+1)};
    if (w >= 23 && w < 27) return {vbyte(2*(w-23)), vbyte(2*(w-23)+1)};
    if (w == 0)  return 16'h0040;
    if (w == 49) return 16'h0300;
    if (w == 60) return CAP[15:0];
    if (w == 61) return CAP[31:16];
    if (w == 82 || w == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  task automatic run_dma(input logic [7:0] op, input int delay);
    logic [15:0] d;
    logic exp_dir;
    exp_dir = (op == 8'hC8);
    wr_reg(3'd7, op);
    @(negedge clk); #1;
    chk(dma_req === 1'b1 && dma_dir === exp_dir, exp_dir ? "R3 dma req/dir" : "R4 dma req/dir",
        {dma_req, dma_dir}, {1'b1, exp_dir});
    rd_reg(3'd7, d);
    chk(d == 16'h00C0, "R3 busy status", d, 16'h00C0);
    // busy write must not disturb the running transfer
    wr_reg(3'd7, exp_dir ? 8'hCA : 8'hC8);
    @(negedge clk); #1;
    chk(dma_req === 1'b1 && dma_dir === exp_dir, "R10 busy cmd ignored", {dma_req, dma_dir}, {1'b1, exp_dir});
    repeat (delay) @(posedge clk);
    chk(irq === 1'b0, "R3 no irq before done", irq, 0);
    pulse_dma();
    @(negedge clk); #1;
    chk(irq === 1'b1 && dma_req === 1'b0, exp_dir ? "R3 done irq" : "R4 done irq", {irq, dma_req}, 2'b10);
    rd_reg(3'd7, d);
    chk(d == 16'h0040, "R3 final status", d, 16'h0040);
    @(negedge clk); #1;
    chk(irq === 1'b0, "R8 status read clears irq", irq, 0);
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd_reg(3'd7, d);
    chk(d == 16'h0040, "R1 reset status", d, 16'h0040);
    chk(irq === 0 && dma_req === 0 && flush_req === 0, "R1 reset outputs", {irq, dma_req, flush_req}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    rd_reg(3'd0, d);
    chk(d == 16'h0000, "R6 data reads 0 without DRQ", d, 0);

    // R2 register readback, random values
    for (int k = 0; k < 12; k++) begin
      logic [7:0] v;
      logic [2:0] a;
      v = 8'($urandom);
      a = 3'(2 + ($urandom % 5));
      wr_reg(a, v);
      rd_reg(a, d);
      chk(d == {8'h00, v}, "R2 register readback", d, v);
      if (a == 3'd2) chk(count == v, "R2 count_o", count, v);
      if (a >= 3'd3 && a <= 3'd5) chk(lba[8*(a-3) +: 8] == v, "R2 lba_o", lba[8*(a-3) +: 8], v);
    end
    wr_reg(3'd6, 8'h40);
    wr_reg(3'd3, 8'h12); wr_reg(3'd4, 8'h34); wr_reg(3'd5, 8'h56);
    chk(lba == 24'h563412, "R2 lba assembly", lba, 24'h563412);

    // R3 / R4 random DMA timing
    for (int k = 0; k < 8; k++)
      run_dma(($urandom % 2) ? 8'hC8 : 8'hCA, $urandom % 6);
    rd_reg(3'd6, d);
    chk(d[4] == 1'b0 && d[7:0] == 8'h40, "R2 device bit 4 after device 0 commands", d, 16'h0040);

    // R5 flush
    wr_reg(3'd7, 8'hE7);
    rd_reg(3'd7, d);
    chk(d == 16'h00C0 && flush_req === 1, "R5 flush busy", d, 16'h00C0);
    repeat (4) @(posedge clk);
    chk(irq === 0 && flush_req === 1, "R5 flush held", {irq, flush_req}, 2'b01);
    @(negedge clk); flush_done = 1; @(posedge clk); #1 flush_done = 0;
    @(negedge clk); #1;
    chk(irq === 1 && flush_req === 0, "R5 flush done", {irq, flush_req}, 2'b10);
    rd_reg(3'd7, d);
    chk(d == 16'h0040, "R5 final status", d, 16'h0040);

    // R8 completion and status read in the same cycle: irq stays set
    wr_reg(3'd7, 8'hC8);
    @(negedge clk); addr = 3'd7; rd = 1; dma_done = 1;
    @(posedge clk); #1 rd = 0; dma_done = 0;
    @(negedge clk); #1;
    chk(irq === 1, "R8 completion wins over read", irq, 1);
    rd_reg(3'd7, d);

    // R6 / R7 identify
    wr_reg(3'd6, 8'h00);
    wr_reg(3'd7, 8'hEC);
    begin
      int bad_st, bad_w;
      bad_st = 0; bad_w = 0;
      for (int w = 0; w < 256; w++) begin
        rd_reg(3'd7, d);
        if (d != 16'h0048) bad_st++;
        rd_reg(3'd0, d);
        if (d != ident_exp(w)) begin
          bad_w++;
          chk(0, "R7 identify word", d, ident_exp(w));
        end
      end
      chk(bad_st == 0, "R6 status 0x48 before every word", bad_st, 0);
      chk(bad_w == 0, "R7 identify content", bad_w, 0);
    end
    rd_reg(3'd7, d);
    chk(d == 16'h0040, "R6 status after last word", d, 16'h0040);
    chk(irq === 0, "R6 identify raises no irq", irq, 0);
    rd_reg(3'd6, d);
    chk(d[4] == 1'b0, "R2 device bit 4 after identify", d, 0);

    // R9 unsupported opcodes
    for (int k = 0; k < 6; k++) begin
      logic [7:0] op;
      op = 8'($urandom);
      if (op == 8'hC8 || op == 8'hCA || op == 8'hE7 || op == 8'hEC) op = 8'h00;
      wr_reg(3'd7, op);
      @(negedge clk); #1;
      chk(irq === 1, "R9 bad opcode irq", irq, 1);
      rd_reg(3'd1, d);
      chk(d == 16'h0004, "R9 error register", d, 16'h0004);
      rd_reg(3'd7, d);
      chk(d == 16'h0041, "R9 status", d, 16'h0041);
    end
    run_dma(8'hC8, 2);
    rd_reg(3'd1, d);
    chk(d == 16'h0000, "R9 err cleared by next command", d, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule